// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

This block is a four-bit synchronous counter that can count in either direction. A parameter chooses between a plain binary sequence of sixteen states and a decimal digit sequence of ten states. All bits of the count change together on the rising clock edge. A low level on the active-low count enable allows counting, and the direction input chooses up or down. A separate active-low preset input copies a data word into the count at once, without waiting for the clock, and it overrides counting for as long as it is held low.

Two outputs let several instances form a wider counter. The terminal flag is a level that stays high for the whole cycle in which the count sits at the last state for the present direction. The active-low chain strobe is low only in the low half of the clock, and only while that terminal state exists and counting is enabled. When every stage shares one clock, each stage's chain strobe drives the next stage's enable, and the stages then count as one multi-digit number.

Top module: `updn_cnt`

## Requirements
- R1: On a rising clock edge the count advances by one step only if `cnt_en_n` is low. While `cnt_en_n` is high the count keeps its value.
- R2: With `dir_dn` low the count goes up by one. With `dir_dn` high it goes down by one.
- R3: While `pre_n` is low, `count` equals `pre_val` within the same time step, at any clock phase. Clock edges with `pre_n` low leave it at `pre_val`, whatever the enable is. Counting resumes from that value after `pre_n` returns high.
- R4: In binary mode (`DECIMAL` = 0), counting up from 15 gives 0 and counting down from 0 gives 15.
- R5: In decimal mode (`DECIMAL` = 1), counting up from 9 gives 0 and counting down from 0 gives 9.
- R6: In decimal mode, a preset value from 10 to 15 goes to 0 on the next enabled up step. On an enabled down step it goes to that value minus one.
- R7: `term` is 1 exactly when the direction is up and the count equals the top state (15 binary, 9 decimal), or when the direction is down and the count is 0. `cnt_en_n` has no effect on it.
- R8: `chain_n` is 0 exactly when `term` is 1, `cnt_en_n` is 0 and `clk` is 0. Otherwise it is 1.
- R9: Two decimal instances on one clock, with the lower stage's `chain_n` feeding the upper stage's `cnt_en_n`, count as a two-digit decimal number from 00 to 99 in both directions and wrap at both ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; the count changes on its rising edge |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| pre_n | input | 1 | Asynchronous preset, active low, overrides counting |
| pre_val | input | 4 | Value loaded by the preset |
| count | output | 4 | Present count |
| term | output | 1 | Terminal state for the present direction |
| chain_n | output | 1 | Cascade strobe, low during the clock's low half at an enabled terminal state |

## Verification
The asynchronous preset and the clocked count step can meet in one cycle. The bench holds `pre_n` low across a rising edge while the enable is active, and expects `count` to stay at `pre_val`. It also drops `pre_n` in the middle of the high phase and expects `count` to follow at once, with the next edge stepping from the new value. A second overlap is a terminal state that comes together with a direction change or a toggling enable. The bench reads `term` and `chain_n` in both clock halves and compares them with a model built only from the requirements.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // Direction encoding as seen on dir_dn
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  // Largest legal state for a given width and numbering variant
  function automatic int unsigned top_state(input int unsigned width, input bit decimal);
    return decimal ? 32'd9 : ((32'd1 << width) - 32'd1);
  endfunction
endpackage

// File: rtl/updn_step.sv
// Next-count logic: one step in the chosen direction with mode-dependent wrap
module updn_step
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter bit          DECIMAL = 1'b0
) (
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(top_state(WIDTH, DECIMAL));

  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] dec_val;

  generate
    if (DECIMAL) begin : g_dec
      // values at or above the top state (illegal codes) fold to zero going up
      always_comb begin
        inc_val = (cur >= TOP) ? '0 : cur + 1'b1;
        dec_val = (cur == '0) ? TOP : cur - 1'b1;
      end
    end else begin : g_bin
      // full binary range: natural modular arithmetic
      always_comb begin
        inc_val = cur + 1'b1;
        dec_val = cur - 1'b1;
      end
    end
  endgenerate

  always_comb begin
    nxt = (dir == DIR_DOWN) ? dec_val : inc_val;
  end
endmodule

// File: rtl/updn_term.sv
// Terminal-state detect and the clock-gated cascade strobe
module updn_term
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter bit          DECIMAL = 1'b0
) (
  input  logic             clk,
  input  logic             pre_n,
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  input  logic             cnt_en_n,
  output logic             term,
  output logic             chain_n
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(top_state(WIDTH, DECIMAL));

  logic at_top;
  logic at_bottom;

  always_comb begin
    at_top    = (cur == TOP);
    at_bottom = (cur == '0);
    term      = (dir == DIR_DOWN) ? at_bottom : at_top;
    chain_n   = ~(term & ~cnt_en_n & ~clk);
  end

  // strobe is never active while the clock is high
  AST_CHAIN_HIGH_PHASE: assert property (@(negedge clk) disable iff (!pre_n)
    chain_n) else $error("chain strobe low in high clock phase"); // R8

  // flag only asserts at an end state matching the direction
  AST_TERM_STATE: assert property (@(posedge clk) disable iff (!pre_n)
    term |-> ((dir == DIR_DOWN) ? (cur == '0) : (cur == TOP)))
    else $error("terminal flag at non-terminal count"); // R7
endmodule

// File: rtl/updn_reg.sv
// Count register with asynchronous preset and clock enable
module updn_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             pre_n,
  input  logic [WIDTH-1:0] pre_val,
  input  logic             cnt_en_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] cur
);
  always_ff @(posedge clk or negedge pre_n) begin
    if (!pre_n) begin
      cur <= pre_val;
    end else if (!cnt_en_n) begin
      cur <= nxt;
    end
  end

  // Checker support: set on an edge with no preset since the previous edge
  logic clean_cycle;
  always_ff @(posedge clk or negedge pre_n) begin
    if (!pre_n) begin
      clean_cycle <= 1'b0;
    end else begin
      clean_cycle <= 1'b1;
    end
  end

  AST_STEP_TAKEN: assert property (@(posedge clk) disable iff (!pre_n)
    !cnt_en_n |=> (!clean_cycle || cur == $past(nxt)))
    else $error("enabled edge did not take the next value"); // R1

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!pre_n)
    cnt_en_n |=> (!clean_cycle || $stable(cur)))
    else $error("count moved while disabled"); // R1

  AST_PRESET_WINS: assert property (@(posedge clk)
    !pre_n |-> (cur == pre_val))
    else $error("count differs from preset value"); // R3
endmodule

// File: rtl/updn_cnt.sv
// Top: reversible counter with preset and cascade outputs
module updn_cnt
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter bit          DECIMAL = 1'b0
) (
  input  logic             clk,
  input  logic             cnt_en_n,
  input  logic             dir_dn,
  input  logic             pre_n,
  input  logic [WIDTH-1:0] pre_val,
  output logic [WIDTH-1:0] count,
  output logic             term,
  output logic             chain_n
);
  dir_e             dir;
  logic [WIDTH-1:0] cur;
  logic [WIDTH-1:0] nxt;

  always_comb begin
    dir   = dir_e'(dir_dn);
    count = cur;
  end

  updn_step #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) u_step (
    .cur (cur),
    .dir (dir),
    .nxt (nxt)
  );

  updn_reg #(.WIDTH(WIDTH)) u_reg (
    .clk      (clk),
    .pre_n    (pre_n),
    .pre_val  (pre_val),
    .cnt_en_n (cnt_en_n),
    .nxt      (nxt),
    .cur      (cur)
  );

  updn_term #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) u_term (
    .clk      (clk),
    .pre_n    (pre_n),
    .cur      (cur),
    .dir      (dir),
    .cnt_en_n (cnt_en_n),
    .term     (term),
    .chain_n  (chain_n)
  );
endmodule

// File: tb/test_updn_cnt.sv
module test_updn_cnt;
  logic       clk = 1'b0;
  logic       cnt_en_n = 1'b1;
  logic       dir_dn = 1'b0;
  logic       pre_n = 1'b1;
  logic [3:0] pre_val = 4'd0;

  logic [3:0] q_b, q_d, q_lo, q_hi;
  logic       tc_b, tc_d, tc_lo, tc_hi;
  logic       rc_b, rc_d, rc_lo, rc_hi;
  logic       en_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected values
  int eb, ed, elo, ehi;

  always #5 clk = ~clk;

  updn_cnt #(.WIDTH(4), .DECIMAL(1'b0)) i_updn_cnt (
    .clk(clk), .cnt_en_n(cnt_en_n), .dir_dn(dir_dn), .pre_n(pre_n),
    .pre_val(pre_val), .count(q_b), .term(tc_b), .chain_n(rc_b));

  updn_cnt #(.WIDTH(4), .DECIMAL(1'b1)) i_dec (
    .clk(clk), .cnt_en_n(cnt_en_n), .dir_dn(dir_dn), .pre_n(pre_n),
    .pre_val(pre_val), .count(q_d), .term(tc_d), .chain_n(rc_d));

  // two-digit decimal chain; the wire delay stands in for board propagation
  updn_cnt #(.WIDTH(4), .DECIMAL(1'b1)) i_lo (
    .clk(clk), .cnt_en_n(cnt_en_n), .dir_dn(dir_dn), .pre_n(pre_n),
    .pre_val(pre_val), .count(q_lo), .term(tc_lo), .chain_n(rc_lo));

  assign #1 en_hi = rc_lo;

  updn_cnt #(.WIDTH(4), .DECIMAL(1'b1)) i_hi (
    .clk(clk), .cnt_en_n(en_hi), .dir_dn(dir_dn), .pre_n(pre_n),
    .pre_val(pre_val), .count(q_hi), .term(tc_hi), .chain_n(rc_hi));

  function automatic int step_of(input int q, input bit dn, input int top);
    if (dn) return (q == 0) ? top : q - 1;
    return (q >= top) ? 0 : q + 1;
  endfunction

  function automatic bit tc_of(input int q, input bit dn, input int top);
    return dn ? (q == 0) : (q == top);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all_counts(input string tag);
    chk(tag, q_b, eb);
    chk(tag, q_d, ed);
    chk({tag, " R9 chain"}, q_hi * 10 + q_lo, ehi * 10 + elo);
    chk("R7 term bin", tc_b, tc_of(eb, dir_dn, 15));
    chk("R7 term dec", tc_d, tc_of(ed, dir_dn, 9));
  endtask

  // one clock cycle: inputs set in the low half, strobes checked in both halves
  task automatic tick(input bit en, input bit dn, input string tag);
    bit lo_tc;
    @(negedge clk);
    cnt_en_n = en;
    dir_dn   = dn;
    #2;
    chk("R8 strobe low half bin", rc_b, !(tc_of(eb, dn, 15) && !en));
    chk("R8 strobe low half dec", rc_d, !(tc_of(ed, dn, 9) && !en));
    chk("R7 term ignores enable", tc_d, tc_of(ed, dn, 9));
    @(posedge clk);
    if (!en) begin
      lo_tc = tc_of(elo, dn, 9);
      if (lo_tc) ehi = step_of(ehi, dn, 9);
      elo = step_of(elo, dn, 9);
      eb  = step_of(eb, dn, 15);
      ed  = step_of(ed, dn, 9);
    end
    #2;
    check_all_counts(tag);
    chk("R8 strobe high half", rc_b & rc_d, 1);
  endtask

  task automatic set_all(input int v);
    eb = v; ed = v; elo = v; ehi = v;
  endtask

  // preset held across a rising edge with counting enabled
  task automatic preset_edge(input int v);
    @(negedge clk);
    pre_val  = 4'(v);
    pre_n    = 1'b0;
    cnt_en_n = 1'b0;
    #2;
    set_all(v);
    chk("R3 preset immediate", q_b, v);
    @(posedge clk);
    #2;
    chk("R3 preset beats edge bin", q_b, v);
    chk("R3 preset beats edge dec", q_d, v);
    @(negedge clk);
    pre_n = 1'b1;
    cnt_en_n = 1'b1;
  endtask

  // preset pulsed in the middle of the high clock phase
  task automatic preset_mid(input int v);
    @(posedge clk);
    #2;
    pre_val = 4'(v);
    pre_n   = 1'b0;
    #1;
    set_all(v);
    chk("R3 mid-cycle preset bin", q_b, v);
    chk("R3 mid-cycle preset dec", q_d, v);
    #1;
    pre_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    // defined starting state via preset
    preset_edge(0);
    chk("R3 start state", q_d, 0);
    // terminal flag with counting disabled (down at zero)
    tick(1'b1, 1'b1, "R1 hold");
    chk("R7 term with enable high", tc_b, 1);
    // down from 0 wraps in both modes
    tick(1'b0, 1'b1, "R4 R5 down wrap");
    chk("R4 bin 0 down", q_b, 15);
    chk("R5 dec 0 down", q_d, 9);
    // up from the top wraps
    tick(1'b0, 1'b0, "R4 R5 up wrap");
    chk("R4 bin 15 up", q_b, 0);
    chk("R5 dec 9 up", q_d, 0);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, "R2 up");
    chk("R2 up count", q_b, 3);
    tick(1'b1, 1'b0, "R1 hold");
    chk("R1 held", q_b, 3);
    // illegal decimal codes
    preset_edge(12);
    tick(1'b0, 1'b1, "R6 illegal down");
    chk("R6 12 down", q_d, 11);
    tick(1'b0, 1'b0, "R6 illegal up");
    chk("R6 12 up to 0", q_d, 0);
    // mid-cycle preset then a step from the new value
    preset_mid(9);
    tick(1'b0, 1'b0, "R3 after mid preset");
    chk("R3 step from preset", q_b, 10);
    // chain across digit boundaries
    preset_edge(0);
    for (int i = 0; i < 120; i++) tick(1'b0, 1'b0, "R9 chain up");
    for (int i = 0; i < 130; i++) tick(1'b0, 1'b1, "R9 chain down");
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = int'($urandom % 32);
      if (r == 0) preset_edge(int'($urandom % 16));
      else if (r == 1) preset_mid(int'($urandom % 16));
      else tick(($urandom % 4) == 0, ($urandom % 3) == 0, "R1 R2 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule